// File: doc/BRIEF.md
# Sequence-Aware Guardband Frequency Selector

This block sits beside an in-order integer pipeline and picks a clock-period code for an adaptive clock generator on every cycle. It watches the retired instruction words and sorts each one into a category: arithmetic/logical, memory, control-flow or multiply/divide. It keeps a short history of the most recent valid instructions. If every instruction in that history is arithmetic/logical, the window is the low-risk sequence class (Class I). If any instruction in it belongs to another category, the window is the high-risk class (Class II).

The class is combined with a voltage/temperature bin from an on-chip condition monitor. The pair indexes a small period table that software fills through a register write port. Each table entry holds a period code and a valid bit. A larger code means a longer period, and the all-ones code is the slowest setting. The output code rises to a longer period at once. It falls to a shorter period by only one step per cycle, so the clock never speeds up abruptly.

Top module: `guardFreqSel`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `clkCode` is the slowest code (all ones, 15 with default widths). The window starts in Class II.
- R2: Instruction category comes from bits [31:30] (format) and bits [24:19] (sub-opcode).
  - Format 11 is memory.
  - Format 01 is control.
  - Format 00 is arithmetic when bits [24:22] equal 100, and control otherwise.
  - Format 10 is multiply/divide when the sub-opcode has bit5=0, bit3=1 and bit1=1, or equals 0x24.
  - Format 10 is control when the sub-opcode is 0x38, 0x39 or 0x3A.
  - Every other format-10 word is arithmetic.
- R3: The window holds the last 4 words presented with `opValid` high. It is Class I only when all 4 are arithmetic. A cycle with `opValid` low leaves the window unchanged, whatever is on `opWord`.
- R4: `flush` refills the window so that it reads Class II. A word that is valid in the same cycle as `flush` is discarded and does not enter the window.
- R5: A write with `regWe` high stores `regWdata` in table entry `regAddr`.
  - `regAddr` = {bin, class}, where class bit 0 means Class I and 1 means Class II.
  - `regWdata[4]` is the valid bit and `regWdata[3:0]` is the code.
  - The entry selected by the current `condBin` and window class sets the target. The written value takes part from the next cycle.
- R6: An invalid entry yields the slowest code as its value.
- R7: The Class II target is the larger of the bin's Class II value and Class I value. At any bin, Class II is therefore never faster than Class I.
- R8: When the target is larger than `clkCode`, `clkCode` takes the target value at the next clock edge.
- R9: When the target is smaller than `clkCode`, `clkCode` drops by exactly one per clock edge until it reaches the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | `opWord` holds a retired instruction this cycle |
| opWord | input | 32 | Retired instruction word |
| flush | input | 1 | Pipeline flush; forces the window to Class II |
| condBin | input | 3 | Voltage/temperature bin from the condition monitor |
| regWe | input | 1 | Table write strobe |
| regAddr | input | 4 | Table entry address {bin, class} |
| regWdata | input | 5 | {valid, code} to store |
| clkCode | output | 4 | Clock-period code sent to the clock generator |

## Verification
Two pairs of events can land in the same cycle.

- A flush and a valid instruction word can arrive together. The bench drives a flush with an arithmetic word after three arithmetic words. It then checks that three more arithmetic words still give Class II timing: the flushed word did not count, so a fourth word is needed.
- A table write can hit the entry that is currently selected while the class or bin is also changing. The bench writes that entry in the same cycle as a risky instruction or a bin change. Its cycle model then predicts which value steers `clkCode` one edge later.

Each predicted code passes through a scoreboard queue and is compared cycle by cycle with the rise-at-once and one-step-down rules applied.

// File: rtl/gfsPkg.sv
package gfsPkg;

  typedef enum logic [1:0] {
    CAT_ALU    = 2'd0,
    CAT_MEM    = 2'd1,
    CAT_CTRL   = 2'd2,
    CAT_MULDIV = 2'd3
  } opCat_e;

  // strobes from the decode control to the window / datapath side
  typedef struct packed {
    logic winShift;   // shift a new category flag into the history
    logic winClear;   // refill history as all-risky (flush)
    logic opRisky;    // incoming word is not arithmetic/logical
  } winStrobe_t;

  localparam int unsigned FMT_HI     = 31;
  localparam int unsigned FMT_LO     = 30;
  localparam int unsigned SUBOP_HI   = 24;
  localparam int unsigned SUBOP_LO   = 19;
  localparam int unsigned BRFMT_HI   = 24;
  localparam int unsigned BRFMT_LO   = 22;

endpackage

// File: rtl/gfsDecode.sv
module gfsDecode
  import gfsPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [31:0] opWord,
  input  logic        flush,
  output opCat_e      opCat,
  output winStrobe_t  strobe
);

  logic [1:0] fmtBits;
  logic [5:0] subOp;
  logic [2:0] brFmt;
  logic       isMulDiv;
  logic       isCtrlJump;

  assign fmtBits = opWord[FMT_HI:FMT_LO];
  assign subOp   = opWord[SUBOP_HI:SUBOP_LO];
  assign brFmt   = opWord[BRFMT_HI:BRFMT_LO];

  logic unusedOpBits;
  assign unusedOpBits = ^{opWord[29:25], opWord[18:0]};

  assign isMulDiv   = (!subOp[5] && subOp[3] && subOp[1]) || (subOp == 6'h24);
  assign isCtrlJump = (subOp[5:2] == 4'b1110) && (subOp[1:0] != 2'b11);

  always_comb begin
    unique case (fmtBits)
      2'b01:   opCat = CAT_CTRL;
      2'b11:   opCat = CAT_MEM;
      2'b00:   opCat = (brFmt == 3'b100) ? CAT_ALU : CAT_CTRL;
      default: begin
        if (isMulDiv)        opCat = CAT_MULDIV;
        else if (isCtrlJump) opCat = CAT_CTRL;
        else                 opCat = CAT_ALU;
      end
    endcase
  end

  // flush outranks a valid word in the same cycle
  always_comb begin
    strobe.winClear = flush;
    strobe.winShift = opValid && !flush;
    strobe.opRisky  = (opCat != CAT_ALU);
  end

  AST_MEM_FORMAT: assert property (@(posedge clk) disable iff (!rstN)
    (opWord[31:30] == 2'b11) |-> (opCat == CAT_MEM)); // R2
  AST_CALL_FORMAT: assert property (@(posedge clk) disable iff (!rstN)
    (opWord[31:30] == 2'b01) |-> (opCat == CAT_CTRL)); // R2

endmodule

// File: rtl/gfsWindow.sv
module gfsWindow
  import gfsPkg::*;
#(
  parameter int unsigned WIN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  winStrobe_t strobe,
  output logic       classTwo
);

  logic [WIN-1:0] riskyHist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riskyHist <= '1;
    end else if (strobe.winClear) begin
      riskyHist <= '1;
    end else if (strobe.winShift) begin
      riskyHist <= {riskyHist[WIN-2:0], strobe.opRisky};
    end
  end

  assign classTwo = |riskyHist;

  AST_FLUSH_CLASS2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.winClear |=> classTwo); // R4
  AST_RISKY_CLASS2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.winShift && strobe.opRisky) |=> classTwo); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.winShift && !strobe.winClear) |=> $stable(classTwo)); // R3

endmodule

// File: rtl/gfsTableDp.sv
module gfsTableDp #(
  parameter int unsigned BIN_W  = 3,
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              classTwo,
  input  logic [BIN_W-1:0]  condBin,
  input  logic              regWe,
  input  logic [BIN_W:0]    regAddr,
  input  logic [CODE_W:0]   regWdata,
  output logic [CODE_W-1:0] clkCode
);

  localparam int unsigned ADDR_W  = BIN_W + 1;
  localparam int unsigned NUM_ENT = 1 << ADDR_W;
  localparam logic [CODE_W-1:0] SLOWEST = '1;

  logic [CODE_W-1:0] entCode  [NUM_ENT];
  logic              entValid [NUM_ENT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        entCode[i]  <= '0;
        entValid[i] <= 1'b0;
      end
    end else if (regWe) begin
      entCode[regAddr]  <= regWdata[CODE_W-1:0];
      entValid[regAddr] <= regWdata[CODE_W];
    end
  end

  logic [ADDR_W-1:0] idxLow, idxHigh;
  logic [CODE_W-1:0] effLow, effHigh, targetCode, curCode;

  assign idxLow  = {condBin, 1'b0};
  assign idxHigh = {condBin, 1'b1};
  assign effLow  = entValid[idxLow]  ? entCode[idxLow]  : SLOWEST;
  assign effHigh = entValid[idxHigh] ? entCode[idxHigh] : SLOWEST;

  always_comb begin
    if (classTwo) targetCode = (effHigh > effLow) ? effHigh : effLow;
    else          targetCode = effLow;
  end

  // rise at once, fall one step per cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCode <= SLOWEST;
    end else if (targetCode > curCode) begin
      curCode <= targetCode;
    end else if (targetCode < curCode) begin
      curCode <= curCode - 1'b1;
    end
  end

  assign clkCode = curCode;

  AST_RISE_NOW: assert property (@(posedge clk) disable iff (!rstN)
    (targetCode > curCode) |=> (curCode == $past(targetCode))); // R8
  AST_SLEW_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (targetCode < curCode) |=> (curCode == $past(curCode) - 1'b1)); // R9
  AST_CLASS2_NOT_FASTER: assert property (@(posedge clk) disable iff (!rstN)
    classTwo |-> (targetCode >= effLow)); // R7

endmodule

// File: rtl/guardFreqSel.sv
module guardFreqSel
  import gfsPkg::*;
#(
  parameter int unsigned BIN_W  = 3,
  parameter int unsigned CODE_W = 4,
  parameter int unsigned WIN    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [31:0]       opWord,
  input  logic              flush,
  input  logic [BIN_W-1:0]  condBin,
  input  logic              regWe,
  input  logic [BIN_W:0]    regAddr,
  input  logic [CODE_W:0]   regWdata,
  output logic [CODE_W-1:0] clkCode
);

  opCat_e     opCat;
  winStrobe_t winStrobe;
  logic       classTwo;

  logic unusedCat;
  assign unusedCat = ^opCat;

  gfsDecode uDecode (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opWord  (opWord),
    .flush   (flush),
    .opCat   (opCat),
    .strobe  (winStrobe)
  );

  gfsWindow #(.WIN(WIN)) uWindow (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (winStrobe),
    .classTwo (classTwo)
  );

  gfsTableDp #(.BIN_W(BIN_W), .CODE_W(CODE_W)) uTable (
    .clk      (clk),
    .rstN     (rstN),
    .classTwo (classTwo),
    .condBin  (condBin),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .clkCode  (clkCode)
  );

endmodule

// File: tb/tb_guardFreqSel.sv
module tb_guardFreqSel;

  localparam int CLK_PERIOD = 10;

  localparam logic [31:0] W_ADD   = 32'h8000_0000;
  localparam logic [31:0] W_OR    = 32'h8010_0000;
  localparam logic [31:0] W_XOR   = 32'h8018_0000;
  localparam logic [31:0] W_SETHI = 32'h0100_0000;
  localparam logic [31:0] W_LD    = 32'hC000_0000;
  localparam logic [31:0] W_CALL  = 32'h4000_0000;
  localparam logic [31:0] W_BR    = 32'h0080_0000;
  localparam logic [31:0] W_UMUL  = 32'h8050_0000;
  localparam logic [31:0] W_SDIV  = 32'h8078_0000;
  localparam logic [31:0] W_MULS  = 32'h8120_0000;
  localparam logic [31:0] W_JMPL  = 32'h81C0_0000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid;
  logic [31:0] opWord;
  logic        flush;
  logic [2:0]  condBin;
  logic        regWe;
  logic [3:0]  regAddr;
  logic [4:0]  regWdata;
  logic [3:0]  clkCode;

  guardFreqSel dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opWord(opWord), .flush(flush),
    .condBin(condBin), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .clkCode(clkCode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [3:0] expQ[$];
  string      tagQ[$];

  // reference state built from the requirements
  logic [3:0] mWin;
  logic [4:0] mTbl [16];
  logic [3:0] mCur;

  task automatic cyc(input logic v, input logic [31:0] w, input logic rk,
                     input logic fl, input logic [2:0] bin, input logic we,
                     input logic [3:0] a, input logic [4:0] d, input string tag);
    logic [3:0] eLo, eHi, tgt;
    opValid = v; opWord = w; flush = fl; condBin = bin;
    regWe = we; regAddr = a; regWdata = d;
    eLo = mTbl[{bin, 1'b0}][4] ? mTbl[{bin, 1'b0}][3:0] : 4'hF;   // R6
    eHi = mTbl[{bin, 1'b1}][4] ? mTbl[{bin, 1'b1}][3:0] : 4'hF;
    tgt = (|mWin) ? ((eHi > eLo) ? eHi : eLo) : eLo;              // R7
    if (tgt > mCur)      mCur = tgt;                               // R8
    else if (tgt < mCur) mCur = mCur - 4'd1;                       // R9
    if (fl)     mWin = 4'hF;                                       // R4
    else if (v) mWin = {mWin[2:0], rk};                            // R3
    if (we) mTbl[a] = d;                                           // R5
    @(posedge clk);
    expQ.push_back(mCur);
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  task automatic op(input logic [31:0] w, input logic rk, input logic [2:0] bin, input string tag);
    cyc(1'b1, w, rk, 1'b0, bin, 1'b0, 4'd0, 5'd0, tag);
  endtask

  task automatic idle(input int n, input logic [2:0] bin, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, W_LD, 1'b1, 1'b0, bin, 1'b0, 4'd0, 5'd0, tag);
  endtask

  task automatic aluRun(input logic [2:0] bin, input string tag);
    op(W_ADD, 1'b0, bin, tag);
    op(W_OR, 1'b0, bin, tag);
    op(W_XOR, 1'b0, bin, tag);
    op(W_SETHI, 1'b0, bin, tag);
  endtask

  // scoreboard monitor
  initial begin
    logic [3:0] e;
    string      t;
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (clkCode !== e) begin
          fails++;
          $display("FAIL %s: clkCode=%0d expected=%0d", t, clkCode, e);
        end
      end
    end
  end

  task automatic directCheck(input logic [3:0] exp, input string tag);
    checks++;
    if (clkCode !== exp) begin
      fails++;
      $display("FAIL %s: clkCode=%0d expected=%0d", tag, clkCode, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; opValid = 1'b0; opWord = '0; flush = 1'b0; condBin = '0;
    regWe = 1'b0; regAddr = '0; regWdata = '0;
    mWin = 4'hF; mCur = 4'hF;
    for (int i = 0; i < 16; i++) mTbl[i] = 5'd0;
    repeat (3) @(negedge clk);
    directCheck(4'hF, "R1 in reset");
    rstN = 1'b1;
    idle(2, 3'd0, "R1 after reset");

    // program table; bin 5 Class I left invalid, bin 6 inverted (R7)
    for (int b = 0; b < 8; b++) begin
      if (b == 6) begin
        cyc(1'b0, W_ADD, 1'b0, 1'b0, 3'd0, 1'b1, {3'(b), 1'b0}, {1'b1, 4'd12}, "R5 write");
        cyc(1'b0, W_ADD, 1'b0, 1'b0, 3'd0, 1'b1, {3'(b), 1'b1}, {1'b1, 4'd4}, "R5 write");
      end else begin
        if (b != 5)
          cyc(1'b0, W_ADD, 1'b0, 1'b0, 3'd0, 1'b1, {3'(b), 1'b0}, {1'b1, 4'(b % 4 + 2)}, "R5 write");
        cyc(1'b0, W_ADD, 1'b0, 1'b0, 3'd0, 1'b1, {3'(b), 1'b1}, {1'b1, 4'(b % 4 + 7)}, "R5 write");
      end
    end

    // Class I reached, step down one per cycle
    aluRun(3'd2, "R3 all arithmetic");
    idle(8, 3'd2, "R9 step down");
    // memory word: longer period at once
    op(W_LD, 1'b1, 3'd2, "R8 rise");
    idle(2, 3'd2, "R8 hold");

    // each risky category, invalid gaps carry risky words
    aluRun(3'd2, "R3");
    idle(6, 3'd2, "R3 invalid ignored");
    op(W_CALL, 1'b1, 3'd2, "R2 call");
    aluRun(3'd2, "R2");
    idle(4, 3'd2, "R2");
    op(W_BR, 1'b1, 3'd2, "R2 branch");
    aluRun(3'd2, "R2");
    idle(4, 3'd2, "R2");
    op(W_UMUL, 1'b1, 3'd2, "R2 mul");
    aluRun(3'd2, "R2");
    idle(4, 3'd2, "R2");
    op(W_SDIV, 1'b1, 3'd2, "R2 div");
    aluRun(3'd2, "R2");
    op(W_MULS, 1'b1, 3'd2, "R2 mulscc");
    aluRun(3'd2, "R2");
    op(W_JMPL, 1'b1, 3'd2, "R2 jump");
    aluRun(3'd2, "R2");
    idle(4, 3'd2, "R2");

    // flush with a valid word in the same cycle
    op(W_ADD, 1'b0, 3'd2, "R4");
    op(W_ADD, 1'b0, 3'd2, "R4");
    op(W_ADD, 1'b0, 3'd2, "R4");
    cyc(1'b1, W_ADD, 1'b0, 1'b1, 3'd2, 1'b0, 4'd0, 5'd0, "R4 flush+valid");
    op(W_OR, 1'b0, 3'd2, "R4");
    op(W_OR, 1'b0, 3'd2, "R4");
    op(W_OR, 1'b0, 3'd2, "R4");
    idle(3, 3'd2, "R4 still class two");
    op(W_OR, 1'b0, 3'd2, "R4");
    idle(6, 3'd2, "R4 class one");

    // invalid entries
    aluRun(3'd5, "R6 invalid class one");
    idle(3, 3'd5, "R6");
    op(W_LD, 1'b1, 3'd2, "R6");
    cyc(1'b0, W_ADD, 1'b0, 1'b0, 3'd2, 1'b1, 4'b0101, 5'd0, "R6 invalidate live");
    idle(3, 3'd2, "R6 slowest");

    // Class II never faster than Class I
    idle(6, 3'd6, "R7 class two uses max");
    aluRun(3'd6, "R7");
    idle(4, 3'd6, "R7 class one");

    // bin changes and live write together with class change
    aluRun(3'd1, "R5");
    idle(5, 3'd1, "R5 bin one");
    idle(3, 3'd3, "R5 bin three");
    idle(3, 3'd0, "R5 bin zero");
    cyc(1'b1, W_LD, 1'b1, 1'b0, 3'd0, 1'b1, 4'b0001, {1'b1, 4'd13}, "R5 write+risky");
    idle(3, 3'd0, "R5");
    cyc(1'b0, W_ADD, 1'b0, 1'b0, 3'd4, 1'b1, 4'b1001, {1'b1, 4'd3}, "R5 write+bin change");
    idle(8, 3'd4, "R5");

    idle(2, 3'd4, "drain");
    @(negedge clk);
    rstN = 1'b0;
    #1;
    directCheck(4'hF, "R1 reset mid-run");
    @(negedge clk);
    rstN = 1'b1;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule